// File: doc/BRIEF.md
# Settled-Sample Pixel Averager with Double Image Store

This block turns a stream of converter samples into image pixels for a scanning imager. The samples arrive much faster than pixels (about 192 kHz of 24-bit samples, while the scan generator issues a pixel tick at a lower and adjustable rate). When a pixel tick arrives, the block forms one pixel from the four samples received most recently. Any older samples are dropped, so the scanning mirrors have time to settle before the samples that count are taken. The average is reduced to a 14-bit pixel and written into the write half of a two-image store.

The other half of the store holds a finished image, and the serial transmitter reads it through a synchronous read port. A frame pulse from the scan generator ends the current image. If the transmitter has already released its image, the two halves exchange roles and `frame_ready_o` goes high. If the transmitter is still busy, the halves keep their roles and the next image is written over the same write half. The transmitter drops `frame_ready_o` by pulsing `rd_done_i`.

The image size is set by parameters. A deployment sets it to 100 x 100. The defaults are kept small.

Top module: `settled_pixel_store`

## Requirements
- R1: On a pixel tick, the stored pixel is bits [25:12] of the 26-bit sum of the four window samples. This equals the upper 14 bits of their 24-bit average, with samples treated as unsigned.
- R2: The window holds only the four most recent valid samples. Any earlier sample has no effect on the pixel. A sample that is valid in the same cycle as a tick belongs to the next pixel.
- R3: If fewer than four samples have arrived since the previous tick (or since reset), the pixel is still formed from the window. Window entries start at zero after reset. In this case `underrun_o` goes high one cycle after the tick and stays high until reset.
- R4: Pixels are written in raster order. The address starts at 0 and advances by one per tick. After the last address it wraps to 0. A frame pulse returns the address to 0. A tick in the same cycle as a frame pulse is written at the old address before the address returns to 0.
- R5: A frame pulse while `frame_ready_o` is low swaps the write and read halves and raises `frame_ready_o` in the next cycle. A frame pulse while `frame_ready_o` is high does not swap, and the next image overwrites the same write half.
- R6: `frame_ready_o` stays high until a cycle with `rd_done_i` high, and it is low from the following cycle. A frame pulse in that same cycle is still refused.
- R7: `rd_data_o` shows, one cycle after `rd_addr_i` is applied, the word at that address of the current read half. Writes never change the read half.
- R8: During and after reset, `frame_ready_o` is low, `underrun_o` is low and `rd_data_o` is zero. The first image is written to half 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SAMPLE_W (24) | Unsigned converter sample |
| pix_tick_i | input | 1 | End of pixel period: store one pixel |
| frame_i | input | 1 | End of image |
| rd_addr_i | input | ADDR_W | Read address in the read half (raster order) |
| rd_done_i | input | 1 | Transmitter has finished the read half |
| rd_data_o | output | PIX_W (14) | Registered read data |
| frame_ready_o | output | 1 | Read half holds an image that has not yet been released |
| underrun_o | output | 1 | Sticky: a pixel was formed from fewer than four fresh samples |

## Verification
The assertions assume that `pix_tick_i`, `frame_i` and `rd_done_i` are single-cycle strobes driven from the same clock. They also assume that the transmitter keeps `rd_addr_i` below the image size. The stimulus follows these rules: each input changes once per cycle on the falling edge, and the read address sweeps only the valid range.

The sequences cover these cases:
- ticks that coincide with samples or with a frame pulse;
- a frame pulse that is refused;
- a release that coincides with a frame pulse;
- more ticks than the image holds;
- pixels that receive far more than four samples.

The underrun case is kept to its own reset interval, because the underrun flag is sticky.

// File: rtl/pxavg_pkg.sv
package pxavg_pkg;
  localparam int unsigned WIN_DEPTH = 4;
  localparam int unsigned WIN_LOG2  = 2;
  typedef enum logic {HALF_0 = 1'b0, HALF_1 = 1'b1} half_e;
endpackage

// File: rtl/sample_window.sv
module sample_window
  import pxavg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned PIX_W    = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                tick_i,
  output logic [PIX_W-1:0]    pix_o,
  output logic                underrun_o
);
  localparam int unsigned SUM_W = SAMPLE_W + WIN_LOG2;
  localparam int unsigned CNT_W = $clog2(WIN_DEPTH + 1);

  logic [SAMPLE_W-1:0] win_q [WIN_DEPTH];
  logic [SUM_W-1:0]    sum;
  logic [CNT_W-1:0]    fresh_q;
  logic                short_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN_DEPTH; i++) win_q[i] <= '0;
    end else if (valid_i) begin
      win_q[0] <= data_i;
      for (int i = 1; i < WIN_DEPTH; i++) win_q[i] <= win_q[i-1];
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < WIN_DEPTH; i++) sum = sum + SUM_W'(win_q[i]);
  end

  // average = sum >> 2, then keep its top PIX_W bits
  assign pix_o     = sum[SUM_W-1 -: PIX_W];
  assign short_win = tick_i && (fresh_q < CNT_W'(WIN_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q <= '0;
    end else if (tick_i) begin
      fresh_q <= valid_i ? CNT_W'(1) : '0;
    end else if (valid_i && fresh_q < CNT_W'(WIN_DEPTH)) begin
      fresh_q <= fresh_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        underrun_o <= 1'b0;
    else if (short_win) underrun_o <= 1'b1;
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o); // R3
  AST_FULL_WINDOW_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fresh_q == CNT_W'(WIN_DEPTH) && !underrun_o) |=> !underrun_o); // R3
  AST_EMPTY_WINDOW_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fresh_q == '0) |=> underrun_o); // R3
endmodule

// File: rtl/buffer_ctrl.sv
module buffer_ctrl
  import pxavg_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              frame_i,
  input  logic              done_i,
  output half_e             wr_half_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              ready_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic swap;
  assign swap = frame_i && !ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_half_o <= HALF_0;
      ready_o   <= 1'b0;
    end else if (swap) begin
      wr_half_o <= (wr_half_o == HALF_0) ? HALF_1 : HALF_0;
      ready_o   <= 1'b1;
    end else if (done_i) begin
      ready_o   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wr_addr_o <= '0;
    else if (frame_i)             wr_addr_o <= '0;
    else if (tick_i)              wr_addr_o <= (wr_addr_o == LAST_ADDR) ? '0
                                               : wr_addr_o + ADDR_W'(1);
  end

  AST_SWAP_ONLY_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_half_o) |-> ($past(frame_i) && !$past(ready_o))); // R5
  AST_READY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !done_i) |=> ready_o); // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frame_i && wr_addr_o != LAST_ADDR) |=> wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)); // R4
  AST_FRAME_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> wr_addr_o == '0); // R4
endmodule

// File: rtl/frame_store.sv
module frame_store
  import pxavg_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned PIX_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  half_e             wr_half_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [PIX_W-1:0]  rd_data_o
);
  localparam int unsigned TOTAL = 2 * DEPTH;
  localparam int unsigned IDX_W = $clog2(TOTAL);

  logic [PIX_W-1:0] mem [TOTAL];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  half_e            rd_half;

  assign rd_half = (wr_half_i == HALF_0) ? HALF_1 : HALF_0;
  assign wr_idx  = (wr_half_i == HALF_1 ? IDX_W'(DEPTH) : '0) + IDX_W'(wr_addr_i);
  assign rd_idx  = (rd_half   == HALF_1 ? IDX_W'(DEPTH) : '0) + IDX_W'(rd_addr_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_idx] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem[rd_idx];
  end

  AST_HALVES_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wr_idx != rd_idx)); // R7
endmodule

// File: rtl/settled_pixel_store.sv
module settled_pixel_store
  import pxavg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned PIX_W    = 14,
  parameter int unsigned IMG_W    = 32,
  parameter int unsigned IMG_H    = 32,
  parameter int unsigned DEPTH    = IMG_W * IMG_H,
  parameter int unsigned ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic                pix_tick_i,
  input  logic                frame_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                rd_done_i,
  output logic [PIX_W-1:0]    rd_data_o,
  output logic                frame_ready_o,
  output logic                underrun_o
);
  logic [PIX_W-1:0]  pix;
  half_e             wr_half;
  logic [ADDR_W-1:0] wr_addr;

  sample_window #(.SAMPLE_W(SAMPLE_W), .PIX_W(PIX_W)) u_window (
    .clk_i, .rst_ni,
    .valid_i   (smp_valid_i),
    .data_i    (smp_data_i),
    .tick_i    (pix_tick_i),
    .pix_o     (pix),
    .underrun_o(underrun_o)
  );

  buffer_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .tick_i   (pix_tick_i),
    .frame_i  (frame_i),
    .done_i   (rd_done_i),
    .wr_half_o(wr_half),
    .wr_addr_o(wr_addr),
    .ready_o  (frame_ready_o)
  );

  frame_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_store (
    .clk_i, .rst_ni,
    .we_i     (pix_tick_i),
    .wr_half_i(wr_half),
    .wr_addr_i(wr_addr),
    .wr_data_i(pix),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/settled_pixel_store_test.sv
module settled_pixel_store_test;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4, IH = 3, N = IW * IH, AW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, pix_tick = 0, frame = 0, rd_done = 0;
  logic [23:0] smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [13:0] rd_data;
  logic frame_ready, underrun;

  settled_pixel_store #(.IMG_W(IW), .IMG_H(IH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .pix_tick_i(pix_tick), .frame_i(frame), .rd_addr_i(rd_addr), .rd_done_i(rd_done),
    .rd_data_o(rd_data), .frame_ready_o(frame_ready), .underrun_o(underrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, ra = 0;
  bit finished = 0;
  string tag = "R8";

  // reference model state
  longint win [4];
  int cnt, waddr, mem [2][N];
  bit wsel, busy, und, ok [2][N], exp_ok;
  int exp_rd;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) win[i] = 0;
    cnt = 0; waddr = 0; wsel = 0; busy = 0; und = 0; exp_rd = 0; exp_ok = 1;
    for (int b = 0; b < 2; b++) for (int a = 0; a < N; a++) ok[b][a] = 0;
  endtask

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (frame_ready !== busy) begin
      bad = 1; $display("FAIL %s frame_ready_o actual %0b expected %0b", tag, frame_ready, busy);
    end
    if (underrun !== und) begin
      bad = 1; $display("FAIL %s underrun_o actual %0b expected %0b", tag, underrun, und);
    end
    if (exp_ok && rd_data !== 14'(exp_rd)) begin
      bad = 1; $display("FAIL %s rd_data_o actual %0h expected %0h", tag, rd_data, exp_rd);
    end
    if (bad) miscompares++;
  endtask

  task automatic step(bit v, logic [23:0] d, bit t, bit f, bit dn);
    longint s;
    int pv;
    @(negedge clk);
    smp_valid = v; smp_data = d; pix_tick = t; frame = f; rd_done = dn; rd_addr = AW'(ra);
    @(posedge clk);
    s = win[0] + win[1] + win[2] + win[3];
    pv = int'((s >> 12) & 64'h3fff);
    exp_rd = mem[!wsel][ra]; exp_ok = ok[!wsel][ra];
    if (t) begin
      mem[wsel][waddr] = pv; ok[wsel][waddr] = 1;
      if (cnt < 4) und = 1;
    end
    if (f) waddr = 0; else if (t) waddr = (waddr + 1) % N;
    if (f && !busy) begin wsel = !wsel; busy = 1; end
    else if (dn) busy = 0;
    if (t) cnt = v ? 1 : 0; else if (v && cnt < 4) cnt++;
    if (v) begin win[3] = win[2]; win[2] = win[1]; win[1] = win[0]; win[0] = longint'(d); end
    ra = (ra + 1) % N;
    #1 compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; smp_valid = 0; pix_tick = 0; frame = 0; rd_done = 0;
    model_reset();
    #2;
    tag = "R8"; compare();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic pixel(int k, bit tick_sample);
    for (int i = 0; i < k; i++) begin
      if (i % 3 == 2) step(0, '0, 0, 0, 0);
      step(1, 24'($urandom()), 0, 0, 0);
    end
    step(tick_sample, 24'($urandom()), 1, 0, 0);
  endtask

  task automatic image(int npix, int k);
    for (int p = 0; p < npix; p++) pixel(k + p % 3, p % 2);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    #3; tag = "R8"; compare();
    do_reset();
    tag = "R1"; image(N, 4);
    // extreme values: all ones and all zeros
    for (int i = 0; i < 4; i++) step(1, 24'hffffff, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 24'h000000, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    tag = "R5"; step(0, '0, 0, 1, 0);             // accepted swap
    tag = "R7"; image(N, 5); idle(2 * N);         // reads under writes
    tag = "R2"; pixel(40, 0); pixel(4, 1); pixel(7, 1);
    tag = "R6"; step(0, '0, 0, 0, 1); idle(3);
    tag = "R5"; step(0, '0, 0, 1, 0);             // swap again
    image(N, 4);
    step(0, '0, 0, 1, 0);                         // refused: reader busy
    tag = "R4"; image(N + 3, 4);                  // overwrite and wrap
    tag = "R6"; step(0, '0, 0, 1, 1);             // release with frame: still refused
    idle(2);
    tag = "R4"; pixel(4, 0); step(1, 24'($urandom()), 1, 1, 0); // tick with frame
    tag = "R7"; idle(2 * N);
    step(0, '0, 0, 0, 1);
    image(N, 4); step(0, '0, 0, 1, 0); idle(2 * N);
    tag = "R3"; do_reset(); tag = "R3";
    step(1, 24'h800000, 0, 0, 0); step(1, 24'h400000, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    idle(3); image(4, 4); step(0, '0, 1, 0, 0);
    step(0, '0, 0, 1, 0); idle(N);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule